// File: doc/BRIEF.md
# Interrupt Vector Ring Producer

This block takes interrupt events from on-chip sources and writes each one into a circular ring in system memory. Each event is packed into a 16-byte vector and sent out as four 32-bit word writes. The block owns the write pointer. The host drains the ring and then reports its progress by writing the read pointer through a small register port. Both pointers count bytes, and both wrap inside a power-of-two ring whose length software chooses.

The ring is not stalled when it fills up. The newest vector overwrites the oldest one, and a sticky overflow flag is set in the readable write-pointer register, so the host can restart reading just past the write pointer. Two further features are optional. The write pointer can be copied to a separate writeback address in memory after every vector. An interrupt line stays high while unread vectors remain or while an overflow is still unacknowledged.

Register map, on a 3-bit register address:

| Address | Register | Contents |
|---|---|---|
| 0 | control | ring enable (bit 0), interrupt enable (bit 1), overflow detection (bit 2), writeback enable (bit 3), overflow clear (bit 4, write-only, reads 0), ring size (bits 12:8), busy (bit 31, read-only) |
| 1 | base | bits 39:8 of the ring byte address |
| 2 | read pointer | byte offset |
| 3 | write pointer | byte offset in bits PTR_W-1:0, overflow flag in bit 31 |
| 4 | writeback address, low | bits 31:0 |
| 5 | writeback address, high | bits 7:0 |

Top module: `ivr_producer`

## Requirements
- R1: After reset, every register reads as zero, `irq` is low and `ev_ready` is low.
- R2: `ev_ready` is high only while the ring is enabled (control bit 0) and no vector is in flight. An event is accepted on a clock edge where `ev_valid` and `ev_ready` are both high.
- R3: In the four cycles that follow acceptance, `mem_we` is high and words 0 to 3 are written in that order. Word k goes to byte address base*256 + write pointer + 4k.
- R4: Word 0 carries the source id in bits 7:0, with zeros above. Word 1 carries the source data in bits 27:0. Word 2 carries the ring id in bits 7:0, the vmid in bits 15:8 and the pasid in bits 31:16. Word 3 is zero.
- R5: The write pointer advances by 16 on the edge that ends word 3. It is read back in bits PTR_W-1:0 of address 3.
- R6: The ring holds 4<<size bytes, with the size field taken from control bits 12:8 and clamped to the range 2..PTR_W-2. Pointers wrap by masking to the ring length.
- R7: If the advanced write pointer equals the read pointer, the vector has overrun unread data. When overflow detection (control bit 2) is on, this sets write-pointer bit 31, and the bit stays set. The write pointer advances in either case.
- R8: Writing control with bit 4 set clears the overflow flag. A new overflow in the same cycle takes priority over the clear.
- R9: With writeback enabled (control bit 3), one more write follows word 3. It goes to address {high[7:0], low[31:0]} and carries the full write-pointer register value.
- R10: Read-pointer writes always take effect. They are masked to the ring and aligned down to 16 bytes. Write-pointer writes take effect only while the ring is disabled and no vector is in flight; at any other time they are ignored.
- R11: Control bit 31 reads 1 while a vector is in flight, including its writeback cycle.
- R12: `irq` is high exactly when the ring is enabled, interrupts are enabled (control bit 1), and either the pointers differ or the overflow flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event can be accepted |
| ev_src_id | input | 8 | Source id |
| ev_src_data | input | 28 | Source data |
| ev_ring_id | input | 8 | Ring id |
| ev_vmid | input | 8 | Virtual machine id |
| ev_pasid | input | 16 | Process address space id |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | 40 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| irq | output | 1 | Interrupt to host |

## Verification
A write pointer that steps by the wrong amount, or masks with the wrong ring length, shows up on `mem_addr` within one vector. The next vector lands at the wrong offset, and the read-back write pointer disagrees with the bench model straight away. An overflow flag that is set too early, too late or not at all shows up at once in two places: bit 31 of the write-pointer register and `irq`. A flag that is wrongly held or wrongly dropped shows up at the next clear or the next read. Wrong word packing, or words written out of order, is caught on the cycle of the bad write. So is a gating fault in `ev_ready`, because the bench holds `ev_valid` high while the ring is disabled and watches `mem_we` stay low.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
    localparam int ADDR_W    = 40;
    localparam int SIZE_W    = 5;
    localparam int REG_A_W   = 3;
    localparam int VEC_BYTES = 16;

    typedef struct packed {
        logic [15:0] pasid;
        logic [7:0]  vmid;
        logic [7:0]  ring_id;
        logic [27:0] src_data;
        logic [7:0]  src_id;
    } ivr_event_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WORDS = 2'd1,
        ST_WB    = 2'd2
    } ivr_state_t;

    localparam logic [REG_A_W-1:0] A_CTRL  = 3'd0;
    localparam logic [REG_A_W-1:0] A_BASE  = 3'd1;
    localparam logic [REG_A_W-1:0] A_RPTR  = 3'd2;
    localparam logic [REG_A_W-1:0] A_WPTR  = 3'd3;
    localparam logic [REG_A_W-1:0] A_WB_LO = 3'd4;
    localparam logic [REG_A_W-1:0] A_WB_HI = 3'd5;

    localparam int B_RING_EN = 0;
    localparam int B_INT_EN  = 1;
    localparam int B_DET_EN  = 2;
    localparam int B_WB_EN   = 3;
    localparam int B_OVF_CLR = 4;
    localparam int B_SIZE_LO = 8;
    localparam int B_FLAG    = 31;
endpackage

// File: rtl/ivr_pack.sv
module ivr_pack
    import ivr_pkg::*;
(
    input  ivr_event_t  ev,
    input  logic [1:0]  word_sel,
    output logic [31:0] word
);
    always_comb begin
        case (word_sel)
            2'd0:    word = {24'd0, ev.src_id};
            2'd1:    word = {4'd0, ev.src_data};
            2'd2:    word = {ev.pasid, ev.vmid, ev.ring_id};
            default: word = 32'd0;
        endcase
    end
endmodule

// File: rtl/ivr_ring_math.sv
module ivr_ring_math
    import ivr_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic [SIZE_W-1:0] size_log2,
    input  logic [PTR_W-1:0]  wptr,
    input  logic [PTR_W-1:0]  rptr,
    output logic [PTR_W-1:0]  mask,
    output logic [PTR_W-1:0]  wptr_adv,
    output logic              overrun,
    output logic              pending
);
    localparam int MIN_LOG = 2;
    localparam int MAX_LOG = PTR_W - 2;
    localparam logic [PTR_W-1:0] ONE  = PTR_W'(1);
    localparam logic [PTR_W-1:0] STEP = PTR_W'(VEC_BYTES);

    logic [SIZE_W:0] eff_log;

    always_comb begin
        if (size_log2 < SIZE_W'(MIN_LOG))
            eff_log = (SIZE_W+1)'(MIN_LOG);
        else if (size_log2 > SIZE_W'(MAX_LOG))
            eff_log = (SIZE_W+1)'(MAX_LOG);
        else
            eff_log = {1'b0, size_log2};
        mask     = (ONE << (eff_log + 2'd2)) - ONE;
        wptr_adv = (wptr + STEP) & mask;
        overrun  = (wptr_adv == rptr);
        pending  = (wptr != rptr);
    end
endmodule

// File: rtl/ivr_producer.sv
module ivr_producer
    import ivr_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ev_valid,
    output logic                ev_ready,
    input  logic [7:0]          ev_src_id,
    input  logic [27:0]         ev_src_data,
    input  logic [7:0]          ev_ring_id,
    input  logic [7:0]          ev_vmid,
    input  logic [15:0]         ev_pasid,
    input  logic                reg_we,
    input  logic [2:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                mem_we,
    output logic [39:0]         mem_addr,
    output logic [31:0]         mem_wdata,
    output logic                irq
);
    localparam int PAD_W = 31 - PTR_W;
    localparam logic [PTR_W-1:0] ALIGN = ~PTR_W'(VEC_BYTES - 1);

    typedef struct packed {
        ivr_state_t        st;
        logic [1:0]        idx;
        ivr_event_t        vec;
        logic [PTR_W-1:0]  wptr;
        logic [PTR_W-1:0]  rptr;
        logic              ovf;
        logic              ring_en;
        logic              int_en;
        logic              det_en;
        logic              wb_en;
        logic [SIZE_W-1:0] size;
        logic [31:0]       base;
        logic [31:0]       wb_lo;
        logic [7:0]        wb_hi;
    } ivr_regs_t;

    ivr_regs_t q, d;

    logic [PTR_W-1:0] mask, wptr_adv;
    logic             overrun, pending;
    logic [31:0]      word;
    logic [31:0]      wptr_reg;
    logic             busy;
    logic             ovf_clr_wr;
    ivr_event_t       ev_in;

    assign ev_in = '{pasid: ev_pasid, vmid: ev_vmid, ring_id: ev_ring_id,
                     src_data: ev_src_data, src_id: ev_src_id};

    ivr_ring_math #(.PTR_W(PTR_W)) u_math (
        .size_log2 (q.size),
        .wptr      (q.wptr),
        .rptr      (q.rptr),
        .mask      (mask),
        .wptr_adv  (wptr_adv),
        .overrun   (overrun),
        .pending   (pending)
    );

    ivr_pack u_pack (
        .ev       (q.vec),
        .word_sel (q.idx),
        .word     (word)
    );

    assign busy       = (q.st != ST_IDLE);
    assign wptr_reg   = {q.ovf, {PAD_W{1'b0}}, q.wptr};
    assign ev_ready   = q.ring_en && !busy;
    assign ovf_clr_wr = reg_we && (reg_addr == A_CTRL) && reg_wdata[B_OVF_CLR];

    always_comb begin
        d = q;
        // register writes first, so the engine below can override them
        if (reg_we) begin
            case (reg_addr)
                A_CTRL: begin
                    d.ring_en = reg_wdata[B_RING_EN];
                    d.int_en  = reg_wdata[B_INT_EN];
                    d.det_en  = reg_wdata[B_DET_EN];
                    d.wb_en   = reg_wdata[B_WB_EN];
                    d.size    = reg_wdata[B_SIZE_LO +: SIZE_W];
                    if (reg_wdata[B_OVF_CLR]) d.ovf = 1'b0;
                end
                A_BASE:  d.base  = reg_wdata;
                A_RPTR:  d.rptr  = reg_wdata[PTR_W-1:0] & mask & ALIGN;
                A_WPTR:  if (!q.ring_en && !busy)
                             d.wptr = reg_wdata[PTR_W-1:0] & mask & ALIGN;
                A_WB_LO: d.wb_lo = reg_wdata;
                A_WB_HI: d.wb_hi = reg_wdata[7:0];
                default: ;
            endcase
        end
        case (q.st)
            ST_IDLE: begin
                if (ev_valid && ev_ready) begin
                    d.vec = ev_in;
                    d.idx = 2'd0;
                    d.st  = ST_WORDS;
                end
            end
            ST_WORDS: begin
                d.idx = q.idx + 2'd1;
                if (q.idx == 2'd3) begin
                    d.wptr = wptr_adv;
                    if (overrun && q.det_en) d.ovf = 1'b1;
                    d.st = q.wb_en ? ST_WB : ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        mem_we    = busy;
        mem_addr  = {q.base, 8'd0} + ADDR_W'(q.wptr) + ADDR_W'({q.idx, 2'b00});
        mem_wdata = word;
        if (q.st == ST_WB) begin
            mem_addr  = {q.wb_hi, q.wb_lo};
            mem_wdata = wptr_reg;
        end
    end

    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = {busy, 18'd0, q.size, 4'd0, q.wb_en, q.det_en, q.int_en, q.ring_en};
            A_BASE:  reg_rdata = q.base;
            A_RPTR:  reg_rdata = 32'(q.rptr);
            A_WPTR:  reg_rdata = wptr_reg;
            A_WB_LO: reg_rdata = q.wb_lo;
            A_WB_HI: reg_rdata = {24'd0, q.wb_hi};
            default: reg_rdata = 32'd0;
        endcase
    end

    assign irq = q.ring_en && q.int_en && (pending || q.ovf);

    // R3
    word0_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ready) |=> (mem_we && mem_wdata[7:0] == $past(ev_src_id)));

    // R5
    wptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.wptr) |-> ($past(q.st == ST_WORDS && q.idx == 2'd3)
                              || $past(reg_we && reg_addr == A_WPTR)));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ovf && !ovf_clr_wr) |=> q.ovf);

    // R10
    wptr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.wptr[3:0] == 4'd0);

    // R12
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (q.ring_en && q.int_en));
endmodule

// File: tb/ivr_producer_tb.sv
module ivr_producer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic        ev_ready;
    logic [7:0]  ev_src_id = '0;
    logic [27:0] ev_src_data = '0;
    logic [7:0]  ev_ring_id = '0;
    logic [7:0]  ev_vmid = '0;
    logic [15:0] ev_pasid = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_we;
    logic [39:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [39:0] RING_ADDR = 40'h00_1234_5600;
    localparam logic [39:0] WB_ADDR   = 40'hAB_0000_1000;
    logic [31:0] exp_wptr = 0, exp_rptr = 0, exp_mask = 32'h3F;
    bit exp_ovf = 0, exp_det = 0, exp_wb = 0;

    always #10ns clk = ~clk;

    ivr_producer u_dut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_src_id(ev_src_id), .ev_src_data(ev_src_data), .ev_ring_id(ev_ring_id),
        .ev_vmid(ev_vmid), .ev_pasid(ev_pasid), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1ns;
        v = reg_rdata;
    endtask

    function automatic logic [31:0] ctrl(input bit int_en, input bit det, input bit wb, input bit clr);
        return {19'd0, 5'd4, 3'd0, clr, wb, det, int_en, 1'b1};
    endfunction

    task automatic send_ev(input logic [7:0] sid, input logic [27:0] sdata,
                           input logic [7:0] rid, input logic [7:0] vm, input logic [15:0] pa);
        logic [31:0] exp_w [4];
        logic [31:0] v;
        exp_w[0] = {24'd0, sid};
        exp_w[1] = {4'd0, sdata};
        exp_w[2] = {pa, vm, rid};
        exp_w[3] = 32'd0;
        @(negedge clk);
        ev_src_id = sid; ev_src_data = sdata; ev_ring_id = rid; ev_vmid = vm; ev_pasid = pa;
        ev_valid = 1'b1;
        #1ns;
        chk(ev_ready == 1'b1, "R2 ready when enabled and idle", 64'(ev_ready), 64'd1);
        @(negedge clk);
        ev_valid = 1'b0;
        for (int w = 0; w < 4; w++) begin
            chk(mem_we == 1'b1, "R3 word write strobe", 64'(mem_we), 64'd1);
            chk(mem_addr == RING_ADDR + 40'(exp_wptr) + 40'(4 * w), "R3 word address",
                64'(mem_addr), 64'(RING_ADDR + 40'(exp_wptr) + 40'(4 * w)));
            chk(mem_wdata == exp_w[w], "R4 word layout", 64'(mem_wdata), 64'(exp_w[w]));
            if (w == 1) begin
                rd_reg(3'd0, v);
                chk(v[31] == 1'b1, "R11 busy in flight", 64'(v[31]), 64'd1);
            end
            @(negedge clk);
        end
        exp_wptr = (exp_wptr + 16) & exp_mask;
        if (exp_wptr == exp_rptr && exp_det) exp_ovf = 1'b1;
        if (exp_wb) begin
            chk(mem_we && mem_addr == WB_ADDR, "R9 writeback address", 64'(mem_addr), 64'(WB_ADDR));
            chk(mem_wdata == {exp_ovf, 15'd0, exp_wptr[15:0]}, "R9 writeback data",
                64'(mem_wdata), 64'({exp_ovf, 15'd0, exp_wptr[15:0]}));
            @(negedge clk);
        end
        chk(mem_we == 1'b0, "R3 exactly the vector writes", 64'(mem_we), 64'd0);
    endtask

    task automatic check_wptr(input string req);
        logic [31:0] v;
        rd_reg(3'd3, v);
        chk(v == {exp_ovf, 15'd0, exp_wptr[15:0]}, req, 64'(v), 64'({exp_ovf, 15'd0, exp_wptr[15:0]}));
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int a = 0; a < 6; a++) begin
            rd_reg(3'(a), v);
            chk(v == 32'd0, "R1 register zero after reset", 64'(v), 64'd0);
        end
        chk(irq == 1'b0, "R1 irq low after reset", 64'(irq), 64'd0);
        chk(ev_ready == 1'b0, "R1 ready low after reset", 64'(ev_ready), 64'd0);
    endtask

    task automatic t_first_vector;
        logic [31:0] v;
        wr_reg(3'd1, 32'h0012_3456);
        exp_det = 1;
        wr_reg(3'd0, ctrl(1, 1, 0, 0));
        send_ev(8'hA5, 28'hABC_DEF1, 8'h11, 8'h22, 16'h3344);
        check_wptr("R5 write pointer after one vector");
        rd_reg(3'd0, v);
        chk(v[31] == 1'b0, "R11 busy clear when idle", 64'(v[31]), 64'd0);
        chk(irq == 1'b1, "R12 irq with unread vector", 64'(irq), 64'd1);
    endtask

    task automatic t_rptr_empty;
        logic [31:0] v;
        wr_reg(3'd2, 32'h0000_0017);
        exp_rptr = 16;
        rd_reg(3'd2, v);
        chk(v == 32'd16, "R10 read pointer aligned", 64'(v), 64'd16);
        chk(irq == 1'b0, "R12 irq low when empty", 64'(irq), 64'd0);
    endtask

    task automatic t_wrap_overflow;
        send_ev(8'h01, 28'h1, 8'h1, 8'h1, 16'h1);
        send_ev(8'h02, 28'h2, 8'h2, 8'h2, 16'h2);
        send_ev(8'h03, 28'h3, 8'h3, 8'h3, 16'h3);
        check_wptr("R6 pointer wrapped to zero");
        send_ev(8'h04, 28'h4, 8'h4, 8'h4, 16'h4);
        check_wptr("R7 overflow flag and advanced pointer");
        chk(irq == 1'b1, "R12 irq held by overflow", 64'(irq), 64'd1);
        @(negedge clk);
        check_wptr("R7 overflow flag sticky");
    endtask

    task automatic t_clear;
        wr_reg(3'd0, ctrl(1, 1, 0, 1));
        exp_ovf = 0;
        check_wptr("R8 overflow cleared");
        chk(irq == 1'b0, "R8 irq low after clear", 64'(irq), 64'd0);
    endtask

    task automatic t_no_detect;
        exp_det = 0;
        wr_reg(3'd0, ctrl(1, 0, 0, 0));
        for (int i = 0; i < 4; i++) send_ev(8'(i), 28'(i), 8'h0, 8'h0, 16'h0);
        check_wptr("R7 no flag with detection off");
    endtask

    task automatic t_writeback;
        exp_det = 1; exp_wb = 1;
        wr_reg(3'd4, 32'h0000_1000);
        wr_reg(3'd5, 32'h0000_01AB);
        wr_reg(3'd0, ctrl(1, 1, 1, 0));
        send_ev(8'h77, 28'h0FF_FFFF, 8'hEE, 8'hDD, 16'hCCBB);
        check_wptr("R9 pointer after writeback vector");
        exp_wb = 0;
    endtask

    task automatic t_int_enable;
        wr_reg(3'd0, ctrl(0, 1, 0, 0));
        send_ev(8'h55, 28'h5, 8'h5, 8'h5, 16'h5);
        chk(irq == 1'b0, "R12 irq masked by enable", 64'(irq), 64'd0);
        wr_reg(3'd0, ctrl(1, 1, 0, 0));
        chk(irq == 1'b1, "R12 irq after enable", 64'(irq), 64'd1);
    endtask

    task automatic t_disable;
        logic [31:0] v;
        wr_reg(3'd3, 32'h0000_0020);
        check_wptr("R10 pointer write ignored while enabled");
        wr_reg(3'd0, 32'd0);
        @(negedge clk);
        ev_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            #1ns;
            chk(ev_ready == 1'b0, "R2 not ready when disabled", 64'(ev_ready), 64'd0);
            chk(mem_we == 1'b0, "R2 no write when disabled", 64'(mem_we), 64'd0);
            @(negedge clk);
        end
        ev_valid = 1'b0;
        chk(irq == 1'b0, "R12 irq low when disabled", 64'(irq), 64'd0);
        wr_reg(3'd3, 32'd0);
        wr_reg(3'd2, 32'd0);
        exp_wptr = 0; exp_rptr = 0;
        check_wptr("R10 pointer reset while disabled");
        rd_reg(3'd2, v);
        chk(v == 32'd0, "R10 read pointer reset", 64'(v), 64'd0);
    endtask

    initial begin
        #(20ns * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_vector();
        t_rptr_empty();
        t_wrap_overflow();
        t_clear();
        t_no_detect();
        t_writeback();
        t_int_enable();
        t_disable();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule